// File: doc/BRIEF.md
# Mode-Switched Serial Load Interface

This block is the serial front end of a sixteen-channel LED PWM driver. A host shifts data in one bit per rising edge of a serial clock, most significant bit first, and the last stage of the shift chain drives a serial output so several blocks can be chained. A mode input picks the chain length: 192 bits when low, for twelve-bit brightness values, and 96 bits when high, for six-bit current-trim values. A rising edge on a latch strobe copies the chain into the brightness register or the trim register, as selected by the mode input.

After a brightness latch the chain is refilled with a status word, which the host can clock out through the serial output. It holds the per-channel open-LED flags, the thermal flag and a copy of the trim register. The first brightness latch after reset, or after a trim latch, is deferred. The brightness register and the status refill take effect on the next serial clock edge, and that edge shifts nothing. The whole update therefore takes 193 serial clocks. All pins are sampled by the system clock `clk`, and edges are found by comparing each sample with the previous one.

Top module: `serial_load_if`

## Requirements
- R1: On a rising edge of `sclk` with no `xlat` edge in the same cycle, the chain moves one place toward its top stage, `sin` enters bit 0, and `sout` always shows the top stage. Data is sent most significant bit first.
- R2: With `mode` low the chain is 192 bits long. A bit shifted in reaches `sout` after 192 shifts counting its own.
- R3: With `mode` high the chain is 96 bits long: only bits 95..0 move, and `sout` shows bit 95.
- R4: A rising edge of `xlat` with `mode` high copies chain bits 95..0 into `dc_word`, and `gs_word` is unchanged.
- R5: A rising edge of `xlat` with `mode` low and no deferral armed copies the whole chain into `gs_word` at once, and `dc_word` is unchanged.
- R6: Channel n uses `gs_word[12n+11:12n]` and `dc_word[6n+5:6n]`. Channel 15 therefore takes the first bits sent.
- R7: A brightness update refills the chain with status: bits 191..176 carry `lod_flags[15:0]` (bit 176 = channel 0), bit 175 carries `therm_flag`, and bits 167..72 carry `dc_word`.
- R8: Status bits 174..168 and 71..0 are zero.
- R9: Reset and every trim latch arm a deferral. The next brightness `xlat` then leaves `gs_word` unchanged. The following `sclk` rise loads `gs_word` and the status word, shifts nothing, and clears the deferral.
- R10: After reset `gs_word`, `dc_word` and `sout` are zero.
- R11: If `xlat` and `sclk` rise in the same cycle, the latch is performed and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock level |
| sin | input | 1 | Serial data in |
| xlat | input | 1 | Latch strobe level |
| mode | input | 1 | 0 = brightness (192-bit), 1 = trim (96-bit) |
| lod_flags | input | 16 | Per-channel open-LED flags for status |
| therm_flag | input | 1 | Thermal flag for status |
| sout | output | 1 | Top stage of the chain |
| gs_word | output | 192 | Latched brightness register |
| dc_word | output | 96 | Latched trim register |

## Verification
The checker assumes that `sclk`, `xlat` and `mode` are already synchronous to `clk`. It also assumes that each level is held for at least one `clk` cycle, so that every edge appears as one sampled rise. It further assumes that `mode` changes only while `sclk` and `xlat` are low. The stimulus drives every pin on the falling edge of `clk`, holds each pulse high for one full cycle and low for at least one cycle, and changes `mode` only between pulses. Same-cycle `xlat` and `sclk` edges are raised only in the single scenario dedicated to R11.

// File: rtl/sld_pkg.sv
package sld_pkg;

    // Action applied to the serial chain in a given cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_SHIFT  = 2'd1,
        ACT_RELOAD = 2'd2
    } sld_act_e;

    // Reserved bits between the thermal flag and the trim copy in status
    localparam int STAT_GAP = 7;

endpackage

// File: rtl/sld_edge.sv
module sld_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_s;

    edge_s state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = lvl;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rise
            assign rise[g] = lvl[g] & ~state_q.prev[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sld_shreg.sv
module sld_shreg
    import sld_pkg::*;
#(
    parameter int LONG_W  = 192,
    parameter int SHORT_W = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sld_act_e          act,
    input  logic              short_mode,
    input  logic              sin,
    input  logic [LONG_W-1:0] load_val,
    output logic              sout,
    output logic [LONG_W-1:0] chain
);

    typedef struct packed {
        logic [LONG_W-1:0] sr;
    } shreg_s;

    shreg_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_SHIFT: begin
                if (short_mode) begin
                    state_d.sr[SHORT_W-1:0] = {state_q.sr[SHORT_W-2:0], sin};
                end else begin
                    state_d.sr = {state_q.sr[LONG_W-2:0], sin};
                end
            end
            ACT_RELOAD: state_d.sr = load_val;
            default:    state_d = state_q;
        endcase
    end

    assign sout  = short_mode ? state_q.sr[SHORT_W-1] : state_q.sr[LONG_W-1];
    assign chain = state_q.sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sld_status.sv
module sld_status
    import sld_pkg::*;
#(
    parameter int CH     = 16,
    parameter int STAT_W = 192,
    parameter int TRIM_W = 96
) (
    input  logic [CH-1:0]     lod,
    input  logic              therm,
    input  logic [TRIM_W-1:0] trim,
    output logic [STAT_W-1:0] word
);

    localparam int LOD_POS   = STAT_W - CH;
    localparam int THERM_POS = LOD_POS - 1;
    localparam int TRIM_POS  = THERM_POS - STAT_GAP - TRIM_W;

    logic [CH-1:0] lod_field;

    genvar g;
    generate
        for (g = 0; g < CH; g++) begin : g_lod
            assign lod_field[g] = lod[g];
        end
    endgenerate

    always_comb begin
        word                        = '0;
        word[LOD_POS +: CH]         = lod_field;
        word[THERM_POS]             = therm;
        word[TRIM_POS +: TRIM_W]    = trim;
    end

endmodule

// File: rtl/serial_load_if.sv
module serial_load_if
    import sld_pkg::*;
#(
    parameter int CH      = 16,
    parameter int GS_BITS = 12,
    parameter int DC_BITS = 6,
    localparam int GS_W   = CH * GS_BITS,
    localparam int DC_W   = CH * DC_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sin,
    input  logic            xlat,
    input  logic            mode,
    input  logic [CH-1:0]   lod_flags,
    input  logic            therm_flag,
    output logic            sout,
    output logic [GS_W-1:0] gs_word,
    output logic [DC_W-1:0] dc_word
);

    typedef struct packed {
        logic [GS_W-1:0] gs;
        logic [DC_W-1:0] dc;
        logic            armed;
        logic            pend;
    } ctrl_s;

    ctrl_s           state_d, state_q;
    logic [1:0]      rise;
    logic            sclk_rise, xlat_rise;
    sld_act_e        act;
    logic [GS_W-1:0] chain;
    logic [GS_W-1:0] status_word;
    logic            armed_q, pend_q;

    sld_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({xlat, sclk}),
        .rise (rise)
    );

    assign sclk_rise = rise[0];
    assign xlat_rise = rise[1];

    sld_status #(.CH(CH), .STAT_W(GS_W), .TRIM_W(DC_W)) u_status (
        .lod  (lod_flags),
        .therm(therm_flag),
        .trim (state_q.dc),
        .word (status_word)
    );

    sld_shreg #(.LONG_W(GS_W), .SHORT_W(DC_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .short_mode(mode),
        .sin       (sin),
        .load_val  (status_word),
        .sout      (sout),
        .chain     (chain)
    );

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        if (xlat_rise) begin
            if (mode) begin
                state_d.dc    = chain[DC_W-1:0];
                state_d.armed = 1'b1;
                state_d.pend  = 1'b0;
            end else if (state_q.armed) begin
                state_d.pend = 1'b1;
            end else begin
                state_d.gs = chain;
                act        = ACT_RELOAD;
            end
        end else if (sclk_rise) begin
            if (state_q.pend) begin
                state_d.gs    = chain;
                state_d.pend  = 1'b0;
                state_d.armed = 1'b0;
                act           = ACT_RELOAD;
            end else begin
                act = ACT_SHIFT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.armed <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign gs_word = state_q.gs;
    assign dc_word = state_q.dc;
    assign armed_q = state_q.armed;
    assign pend_q  = state_q.pend;

endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
    parameter int GS_W = 192,
    parameter int DC_W = 96
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sclk,
    input logic            xlat,
    input logic            mode,
    input logic            sout,
    input logic [GS_W-1:0] gs_word,
    input logic [DC_W-1:0] dc_word,
    input logic            armed,
    input logic            pend
);

    logic sclk_p, xlat_p;
    logic sclk_r, xlat_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            xlat_p <= 1'b0;
        end else begin
            sclk_p <= sclk;
            xlat_p <= xlat;
        end
    end

    assign sclk_r = sclk & ~sclk_p;
    assign xlat_r = xlat & ~xlat_p;

    // R4
    dc_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_word != $past(dc_word)) |-> $past(xlat_r && mode));

    // R5
    gs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_word != $past(gs_word)) |-> $past((xlat_r && !mode && !armed) || (sclk_r && !xlat_r && pend)));

    // R9
    pend_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && sclk_r && !xlat_r) |=> (!pend && !armed));

    // R9
    pend_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(armed));

    // R1
    sout_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sout != $past(sout)) |-> ($past(sclk_r || xlat_r) || (mode != $past(mode))));

endmodule

bind serial_load_if sld_checker #(.GS_W(GS_W), .DC_W(DC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .xlat   (xlat),
    .mode   (mode),
    .sout   (sout),
    .gs_word(gs_word),
    .dc_word(dc_word),
    .armed  (armed_q),
    .pend   (pend_q)
);

// File: tb/tb_serial_load_if.sv
module tb_serial_load_if;

    localparam int GW = 192;
    localparam int DW = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0, sin = 1'b0, xlat = 1'b0, mode = 1'b0;
    logic [15:0]   lod_flags = '0;
    logic          therm_flag = 1'b0;
    logic          sout;
    logic [GW-1:0] gs_word;
    logic [DW-1:0] dc_word;

    int checks = 0;
    int errors = 0;

    serial_load_if dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .xlat(xlat),
        .mode(mode), .lod_flags(lod_flags), .therm_flag(therm_flag),
        .sout(sout), .gs_word(gs_word), .dc_word(dc_word)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_sclk(input logic b);
        @(negedge clk); sin = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic pulse_xlat();
        @(negedge clk); xlat = 1'b1;
        @(negedge clk); xlat = 1'b0;
    endtask

    task automatic shift_bits(input logic [GW-1:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse_sclk(v[i]);
    endtask

    function automatic logic [DW-1:0] mk_dc(input int k);
        logic [DW-1:0] r;
        for (int c = 0; c < 16; c++) r[c*6 +: 6] = 6'((c * 3 + k) % 64);
        return r;
    endfunction

    function automatic logic [GW-1:0] mk_gs(input int k);
        logic [GW-1:0] r;
        for (int c = 0; c < 16; c++) r[c*12 +: 12] = 12'((c * 257 + k) % 4096);
        return r;
    endfunction

    logic [DW-1:0] d1, d2;
    logic [GW-1:0] g1, g2, g3;

    task automatic t_reset();
        check(sout == 1'b0, "R10 sout", GW'(sout), '0);
        check(gs_word == '0, "R10 gs_word", gs_word, '0);
        check(dc_word == '0, "R10 dc_word", GW'(dc_word), '0);
    endtask

    task automatic t_dc_load();
        mode = 1'b1;
        shift_bits(GW'(d1), DW);
        check(sout == d1[DW-1], "R3 sout shows first bit after 96 shifts", GW'(sout), GW'(d1[DW-1]));
        pulse_xlat();
        check(dc_word == d1, "R4 dc_word loaded", GW'(dc_word), GW'(d1));
        check(gs_word == '0, "R4 gs_word untouched", gs_word, '0);
        for (int c = 0; c < 16; c++) begin
            check(dc_word[c*6 +: 6] == 6'((c * 3 + 1) % 64), "R6 trim channel field",
                  GW'(dc_word[c*6 +: 6]), GW'((c * 3 + 1) % 64));
        end
    endtask

    task automatic t_first_gs();
        logic [GW-1:0] exp_s, rd;
        mode = 1'b0;
        lod_flags = 16'hA5C3;
        therm_flag = 1'b1;
        shift_bits(g1, GW);
        pulse_xlat();
        check(gs_word == '0, "R9 deferred after trim latch", gs_word, '0);
        pulse_sclk(1'b0);
        check(gs_word == g1, "R9 extra pulse completes update", gs_word, g1);
        check(dc_word == d1, "R5 dc_word untouched by brightness", GW'(dc_word), GW'(d1));
        exp_s = {16'hA5C3, 1'b1, 7'b0, d1, 72'b0};
        rd = '0;
        for (int k = 0; k < GW; k++) begin
            rd[GW-1-k] = sout;
            pulse_sclk(1'b0);
        end
        check(rd == exp_s, "R7 status word", rd, exp_s);
        check(rd[174:168] == '0 && rd[71:0] == '0, "R8 reserved bits zero",
              GW'({rd[174:168], rd[71:0]}), '0);
        pulse_sclk(1'b1);
        shift_bits('0, 190);
        check(sout == 1'b0, "R2 bit not yet at top after 191 shifts", GW'(sout), '0);
        pulse_sclk(1'b0);
        check(sout == 1'b1, "R2 bit at top after 192 shifts", GW'(sout), GW'(1));
        check(gs_word == g1, "R1 shifting leaves gs_word", gs_word, g1);
    endtask

    task automatic t_gs_normal();
        mode = 1'b0;
        shift_bits(g2, GW);
        check(sout == g2[GW-1], "R1 MSB first at top", GW'(sout), GW'(g2[GW-1]));
        pulse_xlat();
        check(gs_word == g2, "R5 immediate brightness load", gs_word, g2);
        check(dc_word == d1, "R5 dc_word kept", GW'(dc_word), GW'(d1));
        for (int c = 0; c < 16; c++) begin
            check(gs_word[c*12 +: 12] == 12'((c * 257 + 2) % 4096), "R6 brightness channel field",
                  GW'(gs_word[c*12 +: 12]), GW'((c * 257 + 2) % 4096));
        end
    endtask

    task automatic t_rearm();
        mode = 1'b1;
        shift_bits(GW'(d2), DW);
        pulse_xlat();
        check(dc_word == d2, "R4 second trim load", GW'(dc_word), GW'(d2));
        check(gs_word == g2, "R4 gs_word kept", gs_word, g2);
        mode = 1'b0;
        shift_bits(g3, GW);
        pulse_xlat();
        check(gs_word == g2, "R9 re-armed deferral", gs_word, g2);
        pulse_sclk(1'b0);
        check(gs_word == g3, "R9 re-armed commit", gs_word, g3);
    endtask

    task automatic t_collision();
        mode = 1'b0;
        shift_bits(g1, GW);
        @(negedge clk); sin = 1'b1; sclk = 1'b1; xlat = 1'b1;
        @(negedge clk); sclk = 1'b0; xlat = 1'b0;
        check(gs_word == g1, "R11 latch wins, shift dropped", gs_word, g1);
    endtask

    initial begin
        d1 = mk_dc(1);
        d2 = mk_dc(40);
        g1 = mk_gs(9);
        g2 = mk_gs(2);
        g3 = mk_gs(1234);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dc_load();
        t_first_gs();
        t_gs_normal();
        t_rearm();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule